// File: doc/BRIEF.md
# LNB Tone and Shared GPIO Pad Controller

This block produces a continuous square-wave tone of about 22 kHz for controlling a satellite low-noise block, and places it on one bidirectional pad that it shares with a general-purpose I/O bit. The reference clock can run at 4 MHz or at 8 MHz. A configuration input bypasses a divide-by-two prescaler in the 4 MHz case, so the tone divider always advances at a 4 MHz rate and the tone frequency does not change with the reference.

Three static configuration inputs decide what drives the pad. The tone has first claim on the pad. If the tone is not selected, a test source can take the pad. Otherwise the GPIO path drives the pad, or releases it, according to its direction bit. The pad level is brought back through a two-flop synchronizer as a status output. Software can read this status whether the pad is being driven or used as an input.

Top module: `lnb_tone_gpio`

## Requirements
- R1: While reset is asserted and for the first cycles after it, the tone is low and gpio_status_o is 0. The pad follows the mux rules of R5 to R8 with the tone at 0.
- R2: With ref_4mhz_i = 1 (4 MHz reference, prescaler bypassed), the tone first goes high 91 clock edges after tone_sel_i rises, and then toggles every 91 edges. This gives a period of 182 edges at 50% duty.
- R3: With ref_4mhz_i = 0 (8 MHz reference, divide-by-two active), the tone first goes high 182 edges after tone_sel_i rises, and then toggles every 182 edges.
- R4: When tone_sel_i is low for even one clock edge, the divider and prescaler are cleared and the tone is forced low. After it is selected again, the first rising transition of the tone once more comes a full half period later, wherever the previous run had stopped.
- R5: When tone_sel_i = 1, pad_oe_o = 1 and pad_o carries the tone. test_sel_i, gpio_dir_i and gpio_data_i have no effect on the pad.
- R6: When tone_sel_i = 0 and test_sel_i = 1, pad_oe_o = 1 and pad_o equals test_src_i.
- R7: When tone_sel_i = 0, test_sel_i = 0 and gpio_dir_i = 1 (output), pad_oe_o = 1 and pad_o equals gpio_data_i.
- R8: When tone_sel_i = 0, test_sel_i = 0 and gpio_dir_i = 0 (input), pad_oe_o = 0 and the pad is released.
- R9: gpio_status_o equals the value that pad_i had two clock edges earlier, through a two-flop synchronizer. This holds in every pad mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, 4 MHz or 8 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_4mhz_i | input | 1 | 1: 4 MHz reference, prescaler bypassed; 0: 8 MHz reference |
| tone_sel_i | input | 1 | 1: tone drives the pad and the divider runs |
| test_sel_i | input | 1 | 1: test source drives the pad (when tone not selected) |
| test_src_i | input | 1 | Test signal level |
| gpio_dir_i | input | 1 | GPIO direction, 1 = output |
| gpio_data_i | input | 1 | GPIO output data |
| pad_i | input | 1 | Level seen on the pad |
| pad_o | output | 1 | Level driven onto the pad |
| pad_oe_o | output | 1 | Pad output enable, 1 = drive |
| gpio_status_o | output | 1 | Synchronized pad level |

## Verification
The hardest case to reach is restarting the tone from a known phase after it has stopped part-way through a half period. The divider state is not visible at the ports, so the stimulus first lets the tone run past its first high transition. It then drops tone_sel_i for exactly one clock edge, selects the tone again, and measures the edge count to the next rising transition on pad_o. The same measurement is taken with both reference settings, so the prescaler bypass shows up as an exact doubling of the edge counts.

// File: rtl/lnb_pkg.sv
`timescale 1ns/1ps
package lnb_pkg;
  typedef enum logic [1:0] {
    SRC_GPIO = 2'd0,
    SRC_TEST = 2'd1,
    SRC_TONE = 2'd2
  } pad_src_e;

  function automatic pad_src_e pick_src(input logic tone_sel, input logic test_sel);
    if (tone_sel)      return SRC_TONE;
    else if (test_sel) return SRC_TEST;
    else               return SRC_GPIO;
  endfunction
endpackage

// File: rtl/lnb_prescaler.sv
`timescale 1ns/1ps
module lnb_prescaler #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic bypass_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || bypass_i)  cnt_q <= '0;
    else if (wrap)                cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i & (bypass_i | wrap);
endmodule

// File: rtl/lnb_tone_div.sv
`timescale 1ns/1ps
module lnb_tone_div #(
  parameter int unsigned HALF_TICKS = 91
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic tone_o
);
  localparam int unsigned W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [W-1:0] LAST = W'(HALF_TICKS - 1);

  logic [W-1:0] cnt_q;
  logic         tone_q;

  // held cleared while deselected so every run starts low at phase 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        tone_q <= ~tone_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign tone_o = tone_q;
endmodule

// File: rtl/lnb_sync.sv
`timescale 1ns/1ps
module lnb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sr_q[0] <= 1'b0;
          else         sr_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sr_q[g] <= 1'b0;
          else         sr_q[g] <= sr_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lnb_pad_mux.sv
`timescale 1ns/1ps
module lnb_pad_mux
  import lnb_pkg::*;
(
  input  logic tone_sel_i,
  input  logic test_sel_i,
  input  logic tone_i,
  input  logic test_src_i,
  input  logic gpio_dir_i,
  input  logic gpio_data_i,
  output logic pad_o,
  output logic pad_oe_o
);
  pad_src_e src;

  always_comb begin
    src = pick_src(tone_sel_i, test_sel_i);
    unique case (src)
      SRC_TONE: begin pad_o = tone_i;      pad_oe_o = 1'b1;       end
      SRC_TEST: begin pad_o = test_src_i;  pad_oe_o = 1'b1;       end
      default:  begin pad_o = gpio_data_i; pad_oe_o = gpio_dir_i; end
    endcase
  end
endmodule

// File: rtl/lnb_tone_gpio.sv
`timescale 1ns/1ps
module lnb_tone_gpio #(
  parameter int unsigned PRESCALE    = 2,
  parameter int unsigned HALF_TICKS  = 91,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_4mhz_i,
  input  logic tone_sel_i,
  input  logic test_sel_i,
  input  logic test_src_i,
  input  logic gpio_dir_i,
  input  logic gpio_data_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic gpio_status_o
);
  logic tick_w;
  logic tone_w;

  lnb_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (tone_sel_i),
    .bypass_i (ref_4mhz_i),
    .tick_o   (tick_w)
  );

  lnb_tone_div #(.HALF_TICKS(HALF_TICKS)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tone_sel_i),
    .tick_i (tick_w),
    .tone_o (tone_w)
  );

  lnb_pad_mux u_mux (
    .tone_sel_i  (tone_sel_i),
    .test_sel_i  (test_sel_i),
    .tone_i      (tone_w),
    .test_src_i  (test_src_i),
    .gpio_dir_i  (gpio_dir_i),
    .gpio_data_i (gpio_data_i),
    .pad_o       (pad_o),
    .pad_oe_o    (pad_oe_o)
  );

  lnb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (gpio_status_o)
  );
endmodule

// File: rtl/lnb_tone_gpio_chk.sv
`timescale 1ns/1ps
module lnb_tone_gpio_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tone_sel_i,
  input logic test_sel_i,
  input logic test_src_i,
  input logic gpio_dir_i,
  input logic gpio_data_i,
  input logic pad_i,
  input logic pad_o,
  input logic pad_oe_o,
  input logic gpio_status_o,
  input logic tone_w
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  // R5
  tone_owns_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_sel_i |-> (pad_oe_o && pad_o == tone_w));

  // R6
  test_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tone_sel_i && test_sel_i) |-> (pad_oe_o && pad_o == test_src_i));

  // R7
  gpio_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tone_sel_i && !test_sel_i && gpio_dir_i) |-> (pad_oe_o && pad_o == gpio_data_i));

  // R8
  gpio_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tone_sel_i && !test_sel_i && !gpio_dir_i) |-> !pad_oe_o);

  // R4
  tone_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tone_sel_i |=> !tone_w);

  // R9
  status_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (gpio_status_o == $past(pad_i, 2)));
endmodule

bind lnb_tone_gpio lnb_tone_gpio_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tone_sel_i    (tone_sel_i),
  .test_sel_i    (test_sel_i),
  .test_src_i    (test_src_i),
  .gpio_dir_i    (gpio_dir_i),
  .gpio_data_i   (gpio_data_i),
  .pad_i         (pad_i),
  .pad_o         (pad_o),
  .pad_oe_o      (pad_oe_o),
  .gpio_status_o (gpio_status_o),
  .tone_w        (tone_w)
);

// File: tb/lnb_tone_gpio_bench.sv
`timescale 1ns/1ps
module lnb_tone_gpio_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_4mhz = 1'b1;
  logic tone_sel = 1'b0;
  logic test_sel = 1'b0;
  logic test_src = 1'b0;
  logic gpio_dir = 1'b1;
  logic gpio_data = 1'b0;
  logic ext_lvl = 1'b0;
  logic pad_in;
  logic pad_out, pad_oe, status;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  assign pad_in = pad_oe ? pad_out : ext_lvl;

  lnb_tone_gpio u_lnb_tone_gpio (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ref_4mhz_i    (ref_4mhz),
    .tone_sel_i    (tone_sel),
    .test_sel_i    (test_sel),
    .test_src_i    (test_src),
    .gpio_dir_i    (gpio_dir),
    .gpio_data_i   (gpio_data),
    .pad_i         (pad_in),
    .pad_o         (pad_out),
    .pad_oe_o      (pad_oe),
    .gpio_status_o (status)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {tone_sel, test_sel, test_src, dir, data, exp_oe, exp_out}
  localparam logic [6:0] VEC [8] = '{
    7'b11100_10, 7'b10011_10, 7'b01100_11, 7'b01011_10,
    7'b00011_11, 7'b00010_10, 7'b00001_01, 7'b00000_00
  };

  task automatic tone_run(input logic ref4, input int half, input string tag);
    int rise = -1;
    int fall = -1;
    @(negedge clk);
    tone_sel = 1'b0;
    ref_4mhz = ref4;
    @(negedge clk);
    tone_sel = 1'b1;
    for (int n = 1; n <= 2 * half + 2; n++) begin
      @(negedge clk);
      if (rise < 0 && pad_out) rise = n;
      else if (rise >= 0 && fall < 0 && !pad_out) fall = n;
    end
    check({tag, " first rise"}, rise, half);
    check({tag, " first fall"}, fall, 2 * half);
  endtask

  initial begin
    #3;
    // R1 reset state
    check("R1 status in reset", int'(status), 0);
    check("R1 oe in reset", int'(pad_oe), 1);
    check("R1 pad in reset", int'(pad_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", int'(status), 0);

    foreach (VEC[i]) begin
      string tag;
      @(negedge clk);
      {tone_sel, test_sel, test_src, gpio_dir, gpio_data} = VEC[i][6:2];
      @(negedge clk);
      tag = VEC[i][6] ? "R5" : VEC[i][5] ? "R6" : VEC[i][3] ? "R7" : "R8";
      check({tag, " oe"}, int'(pad_oe), int'(VEC[i][1]));
      if (VEC[i][1]) check({tag, " pad"}, int'(pad_out), int'(VEC[i][0]));
    end

    @(negedge clk);
    {tone_sel, test_sel, test_src, gpio_dir, gpio_data} = 5'b00010;
    tone_run(1'b1, 91, "R2");
    tone_run(1'b0, 182, "R3");

    // R4: stop mid half-period, then restart
    tone_run(1'b1, 91, "R4 prep");
    repeat (40) @(negedge clk);
    tone_run(1'b1, 91, "R4 restart");
    tone_run(1'b0, 182, "R4 restart 8M");

    // R5: tone ignores GPIO and test inputs while selected
    @(negedge clk);
    test_sel = 1'b1; test_src = 1'b1; gpio_dir = 1'b0; gpio_data = 1'b1;
    @(negedge clk);
    check("R5 oe with others set", int'(pad_oe), 1);

    // R9 synchronizer latency, input mode
    @(negedge clk);
    tone_sel = 1'b0; test_sel = 1'b0; gpio_dir = 1'b0; ext_lvl = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 input low settled", int'(status), 0);
    ext_lvl = 1'b1;
    @(negedge clk);
    check("R9 one edge", int'(status), 0);
    @(negedge clk);
    check("R9 two edges", int'(status), 1);
    ext_lvl = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 input falls", int'(status), 0);

    // R9 readback while driving
    gpio_dir = 1'b1; gpio_data = 1'b1; ext_lvl = 1'b0;
    @(negedge clk);
    check("R9 drive one edge", int'(status), 0);
    @(negedge clk);
    check("R9 drive readback", int'(status), 1);

    // R1 reset clears synchronizer
    rst_n = 1'b0;
    #1;
    check("R1 status on reset", int'(status), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule